// File: doc/BRIEF.md
# Parity Bus Transceiver with Error Latch

This block joins two byte-wide buses and carries a ninth parity bit with the byte. The byte goes from the A side to the B side, and a generated bit is added so that the nine bits together hold an odd number of ones. In the other direction, the incoming B byte and its parity bit are checked. A result with an even count is reported as an error. Each bus has its own active-low output enable. If both enables are inactive, the two buses are isolated from each other. If both are active, the byte still goes from A to B, but the parity bit is inverted on purpose. This lets software inject a fault and confirm that the error path reacts.

The check result feeds a one-bit error flag. Two controls, a latch enable and an active-low clear, set how the flag behaves. The flag can follow the check result on each clock, capture an error and hold it, or be reset. The flag leaves the block as a pull-down enable for an open-drain, active-low error line: a high `err_pull` means the line is held low and an error is signalled. Every tri-state pad is split into separate input, output and drive-enable signals.

Top module: `par_xcvr`

## Requirements
- R1: With `b_oe_n`=0 and `a_oe_n`=1, `b_out` equals `a_in`, `b_drv`=1, and the A side is not driven (`a_drv`=0, `a_out`=0).
- R2: In that same A-to-B state, `par_drv`=1 and `par_out` is 1 exactly when `a_in` holds an even number of ones. The nine bits driven out therefore always carry odd parity.
- R3: With `a_oe_n`=0 and `b_oe_n`=1, `a_out` equals `b_in` and `a_drv`=1. `b_drv` and `par_drv` are 0, and `b_out` and `par_out` are 0.
- R4: With both enables at 0, `b_out` equals `a_in` and `b_drv`=1, and `par_out` is 1 exactly when `a_in` holds an odd number of ones. The A side is not driven.
- R5: With both enables at 1, all three drive enables are 0 and all outputs are 0. The error check still runs on `b_in` plus `par_in`.
- R6: When `le`=0, `err_pull` after the next clock edge equals the check result, whatever the value of `clr_n`. With B not driven, the result is an error (1) exactly when `b_in` plus `par_in` hold an even number of ones.
- R7: While the block drives B, the check uses the driven byte and parity bit. A-to-B mode therefore gives no error, and the inverted-parity mode always gives an error.
- R8: With `le`=1 and `clr_n`=0, `err_pull` is 0 after the next clock edge.
- R9: With `le`=1 and `clr_n`=1, `err_pull` becomes 1 after the next edge if the check shows an error. Otherwise it keeps its value, so an error once captured stays until it is cleared.
- R10: While `rst`=1, all drive enables are 0. After a clock edge with `rst`=1, `err_pull` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the error flag |
| rst | input | 1 | Synchronous reset, active high |
| a_oe_n | input | 1 | Active-low enable for driving the A bus |
| b_oe_n | input | 1 | Active-low enable for driving the B bus and the parity bit |
| le | input | 1 | Flag latch enable (0 = follow the check result) |
| clr_n | input | 1 | Active-low flag clear, used when `le`=1 |
| a_in | input | DATA_W | Value seen on the A pads |
| a_out | output | DATA_W | Value to drive onto the A pads |
| a_drv | output | 1 | Drive enable for the A pads |
| b_in | input | DATA_W | Value seen on the B pads |
| b_out | output | DATA_W | Value to drive onto the B pads |
| b_drv | output | 1 | Drive enable for the B pads |
| par_in | input | 1 | Value seen on the parity pad |
| par_out | output | 1 | Value to drive onto the parity pad |
| par_drv | output | 1 | Drive enable for the parity pad |
| err_pull | output | 1 | Pull-down enable of the open-drain error line (1 = error) |

## Verification
The bench builds the block with the default `DATA_W` of 8. This keeps the input space small enough to cover in full. With that width, every A byte is applied in the A-to-B mode and in the inverted-parity mode, and all 512 pairs of B byte and parity bit are applied in both the B-to-A mode and the isolation mode. Every parity value is therefore checked exactly. A directed run then takes the flag through the follow, capture, hold and clear steps, including the cases where the clear is ignored and where a held error outlasts a good check.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   typedef enum logic [1:0] {
      XM_ISO  = 2'd0,
      XM_A2B  = 2'd1,
      XM_B2A  = 2'd2,
      XM_DIAG = 2'd3
   } xmode_e;

   function automatic xmode_e decode_mode(input logic a_oe_n, input logic b_oe_n);
      xmode_e m;
      case ({a_oe_n, b_oe_n})
         2'b10:   m = XM_A2B;
         2'b01:   m = XM_B2A;
         2'b00:   m = XM_DIAG;
         default: m = XM_ISO;
      endcase
      return m;
   endfunction
endpackage

// File: rtl/parity_tree.sv
module parity_tree #(
   parameter int unsigned N = 9
) (
   input  logic [N-1:0] bits,
   output logic         odd
);
   if (N < 1) begin : g_bad_width
      $error("parity_tree: N must be at least 1");
   end

   assign odd = ^bits;
endmodule

// File: rtl/err_latch.sv
module err_latch (
   input  logic clk,
   input  logic rst,
   input  logic le,
   input  logic clr_n,
   input  logic fault,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (rst)         flag <= 1'b0;
      else if (!le)    flag <= fault;
      else if (!clr_n) flag <= 1'b0;
      else if (fault)  flag <= 1'b1;
   end
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
   import xcvr_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         rst,
   input  logic         a_oe_n,
   input  logic         b_oe_n,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   input  logic         a_odd,
   output logic [W-1:0] a_out,
   output logic         a_drv,
   output logic [W-1:0] b_out,
   output logic         b_drv,
   output logic         par_out,
   output logic         par_drv
);
   xmode_e mode;
   logic   toward_b;
   logic   toward_a;

   assign mode     = rst ? XM_ISO : decode_mode(a_oe_n, b_oe_n);
   assign toward_b = (mode == XM_A2B) || (mode == XM_DIAG);
   assign toward_a = (mode == XM_B2A);

   for (genvar i = 0; i < W; i++) begin : g_lane
      assign b_out[i] = a_in[i] & toward_b;
      assign a_out[i] = b_in[i] & toward_a;
   end

   assign b_drv   = toward_b;
   assign a_drv   = toward_a;
   assign par_drv = toward_b;
   assign par_out = toward_b & ((mode == XM_DIAG) ? a_odd : ~a_odd);
endmodule

// File: rtl/par_xcvr.sv
module par_xcvr #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              a_oe_n,
   input  logic              b_oe_n,
   input  logic              le,
   input  logic              clr_n,
   input  logic [DATA_W-1:0] a_in,
   output logic [DATA_W-1:0] a_out,
   output logic              a_drv,
   input  logic [DATA_W-1:0] b_in,
   output logic [DATA_W-1:0] b_out,
   output logic              b_drv,
   input  logic              par_in,
   output logic              par_out,
   output logic              par_drv,
   output logic              err_pull
);
   localparam int unsigned CW = DATA_W + 1;

   if (DATA_W < 1) begin : g_bad_width
      $error("par_xcvr: DATA_W must be at least 1");
   end

   logic          a_odd;
   logic [CW-1:0] chk_bits;
   logic          chk_odd;

   parity_tree #(.N(DATA_W)) u_agen (.bits(a_in), .odd(a_odd));

   xcvr_path #(.W(DATA_W)) u_path (
      .rst(rst), .a_oe_n(a_oe_n), .b_oe_n(b_oe_n),
      .a_in(a_in), .b_in(b_in), .a_odd(a_odd),
      .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv),
      .par_out(par_out), .par_drv(par_drv)
   );

   // The check watches the B pads; when they are driven, use the driven value.
   assign chk_bits = b_drv ? {b_out, par_out} : {b_in, par_in};

   parity_tree #(.N(CW)) u_chk (.bits(chk_bits), .odd(chk_odd));

   err_latch u_flag (
      .clk(clk), .rst(rst), .le(le), .clr_n(clr_n),
      .fault(~chk_odd), .flag(err_pull)
   );
endmodule

// File: rtl/par_xcvr_chk.sv
module par_xcvr_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              a_oe_n,
   input logic              b_oe_n,
   input logic              le,
   input logic              clr_n,
   input logic [DATA_W-1:0] a_in,
   input logic [DATA_W-1:0] b_in,
   input logic [DATA_W-1:0] a_out,
   input logic              a_drv,
   input logic [DATA_W-1:0] b_out,
   input logic              b_drv,
   input logic              par_out,
   input logic              par_drv,
   input logic              err_pull
);
   assert_a2b_route_R1: assert property (@(posedge clk) disable iff (rst)
      (a_oe_n && !b_oe_n) |-> (b_drv && b_out == a_in && !a_drv));

   assert_a2b_odd_R2: assert property (@(posedge clk) disable iff (rst)
      (a_oe_n && !b_oe_n) |-> (par_drv && (^{b_out, par_out})));

   assert_b2a_route_R3: assert property (@(posedge clk) disable iff (rst)
      (!a_oe_n && b_oe_n) |-> (a_drv && a_out == b_in && !b_drv && !par_drv));

   assert_diag_even_R4: assert property (@(posedge clk) disable iff (rst)
      (!a_oe_n && !b_oe_n) |-> (!a_drv && b_drv && !(^{b_out, par_out})));

   assert_iso_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      (a_oe_n && b_oe_n) |-> (!a_drv && !b_drv && !par_drv));

   assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
      (le && !clr_n) |=> !err_pull);

   assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (le && clr_n && err_pull) |=> err_pull);

   always_ff @(posedge clk) begin
      if (rst) begin
         assert_reset_quiet_R10: assert (!a_drv && !b_drv && !par_drv);
      end
   end
endmodule

bind par_xcvr par_xcvr_chk #(.DATA_W(DATA_W)) u_chk_bind (
   .clk(clk), .rst(rst), .a_oe_n(a_oe_n), .b_oe_n(b_oe_n),
   .le(le), .clr_n(clr_n), .a_in(a_in), .b_in(b_in),
   .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv),
   .par_out(par_out), .par_drv(par_drv), .err_pull(err_pull)
);

// File: tb/sim_par_xcvr.sv
`timescale 1ns/100ps
module sim_par_xcvr;
   localparam int unsigned W = 8;

   typedef struct {
      logic [W-1:0] a_out;
      logic         a_drv;
      logic [W-1:0] b_out;
      logic         b_drv;
      logic         par_out;
      logic         par_drv;
      logic         err;
      string        tag;
   } item_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         a_oe_n = 1'b1, b_oe_n = 1'b1, le = 1'b0, clr_n = 1'b1;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic         par_in = 1'b0;
   logic [W-1:0] a_out, b_out;
   logic         a_drv, b_drv, par_out, par_drv, err_pull;

   int    n_chk = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;
   logic  mdl_flag = 1'b0;
   item_t sb[$];

   always #2.5 clk = ~clk;

   par_xcvr #(.DATA_W(W)) u0 (
      .clk(clk), .rst(rst), .a_oe_n(a_oe_n), .b_oe_n(b_oe_n),
      .le(le), .clr_n(clr_n), .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
      .b_in(b_in), .b_out(b_out), .b_drv(b_drv), .par_in(par_in),
      .par_out(par_out), .par_drv(par_drv), .err_pull(err_pull)
   );

   task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic p,
                        input logic aoe, input logic boe, input logic l,
                        input logic c, input string tag);
      item_t e;
      logic  to_b, diag, to_a, fault;
      @(posedge clk);
      #1;
      a_in = a; b_in = b; par_in = p; a_oe_n = aoe; b_oe_n = boe; le = l; clr_n = c;
      to_b = !boe;
      diag = !boe && !aoe;
      to_a = !aoe && boe;
      e.b_drv   = to_b;
      e.b_out   = to_b ? a : '0;
      e.par_drv = to_b;
      e.par_out = to_b ? (diag ? (^a) : ~(^a)) : 1'b0;
      e.a_drv   = to_a;
      e.a_out   = to_a ? b : '0;
      fault     = to_b ? diag : ~(^{b, p});
      if (!l)        mdl_flag = fault;
      else if (!c)   mdl_flag = 1'b0;
      else if (fault) mdl_flag = 1'b1;
      e.err = mdl_flag;
      e.tag = tag;
      sb.push_back(e);
   endtask

   // Monitor: one item per cycle, compared after the edge that updates the flag.
   initial begin
      forever begin
         @(posedge clk);
         #0.5;
         if (sb.size() > 0) begin
            item_t e;
            e = sb.pop_front();
            n_chk++;
            if (a_out !== e.a_out || a_drv !== e.a_drv || b_out !== e.b_out ||
                b_drv !== e.b_drv || par_out !== e.par_out || par_drv !== e.par_drv ||
                err_pull !== e.err) begin
               n_bad++;
               $display("FAIL %s: got a=%h/%b b=%h/%b p=%b/%b err=%b, expected a=%h/%b b=%h/%b p=%b/%b err=%b",
                        e.tag, a_out, a_drv, b_out, b_drv, par_out, par_drv, err_pull,
                        e.a_out, e.a_drv, e.b_out, e.b_drv, e.par_out, e.par_drv, e.err);
            end
         end
      end
   end

   initial begin
      // R10: reset with B enable active must leave all drivers off and flag clear.
      b_oe_n = 1'b0; a_in = 8'hFF;
      repeat (3) @(posedge clk);
      #1;
      n_chk++;
      if (a_drv !== 1'b0 || b_drv !== 1'b0 || par_drv !== 1'b0 || err_pull !== 1'b0) begin
         n_bad++;
         $display("FAIL R10: got drv=%b%b%b err=%b, expected drv=000 err=0",
                  a_drv, b_drv, par_drv, err_pull);
      end
      rst = 1'b0; b_oe_n = 1'b1; mdl_flag = 1'b0;

      for (int i = 0; i < 256; i++) apply(i[W-1:0], 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R1 R2 R7 a2b");
      for (int i = 0; i < 512; i++) apply(8'h00, i[8:1], i[0], 1'b0, 1'b1, 1'b0, i[2], "R3 R6 b2a");
      for (int i = 0; i < 512; i++) apply(8'hA5, i[8:1], i[0], 1'b1, 1'b1, 1'b0, 1'b1, "R5 R6 iso");
      for (int i = 0; i < 256; i++) apply(i[W-1:0], 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R4 R7 diag");

      // Flag sequence: good = 8'h01/0 (odd), bad = 8'h03/0 (even).
      apply(8'h00, 8'h03, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R6 pass bad");
      apply(8'h00, 8'h01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R6 pass good");
      apply(8'h00, 8'h01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R9 store good");
      apply(8'h00, 8'h03, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R9 sample bad");
      apply(8'h00, 8'h01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R9 hold error");
      apply(8'h00, 8'h01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R9 hold in b2a");
      apply(8'h00, 8'h03, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R8 clear over bad");
      apply(8'h00, 8'h03, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R6 pass ignores clr");
      apply(8'h00, 8'h01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R8 clear");
      apply(8'h3C, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R7 R9 diag sample");
      apply(8'h3C, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R7 R9 a2b hold");
      apply(8'h3C, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R7 a2b pass");

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got no finish, expected end of run");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule